// File: doc/BRIEF.md
# Hash Operand and Result Register Bank

This block sits between a host processor and a hash engine. The host writes the operand words of a hash into word registers on a simple bus. The block keeps them in registers and drives them to the engine as one wide vector. When the host writes the last operand word, the block sends the engine a one-cycle start pulse. The engine returns its result later, one word per cycle. It flags the final word, and the delay is not fixed, because requests can queue inside the engine. The block stores the returned words and raises a completion flag.

The word addresses do different things for writes and reads. A write to a word address loads an operand, and a read from the same address returns the result word. The host has two ways to get a result. It can poll a status address until it reads exactly one and then read the result words. Or it can read a result word at once: the bus then holds back the read acknowledge until the result has arrived. The hash computation itself is not part of this block.

Top module: `hash_result_regs`

## Requirements
- R1: Addresses 0 to N_WORDS-1 select word i of the operand (on write) and of the result (on read). Address N_WORDS is the status register. Higher addresses are unmapped.
- R2: A write to word address i loads operand word i. From the next cycle `op_data[i*DATA_W +: DATA_W]` presents it.
- R3: A write to address N_WORDS-1 drives `op_start` high for exactly the following cycle. Writes to other addresses produce no start pulse.
- R4: Any write to a word address clears the completion flag. The status reads 0 afterwards, even if the engine's final word arrives in the same cycle.
- R5: Result words are stored in arrival order, the first at address 0. A word with `res_last` set sets the completion flag and makes the next word go to address 0 again.
- R6: The status register reads 0x00000001 when the completion flag is set and 0x00000000 otherwise. Bits 31:1 are always zero.
- R7: A read of the status register or of an unmapped address is acknowledged one cycle after the request is presented. An unmapped read returns zero.
- R8: A read of a result word is acknowledged only while the completion flag is set. Until then `hb_rack` stays low and the read stalls.
- R9: A stalled result read is acknowledged in the cycle after the final result word is captured, and returns the newly captured value.
- R10: Each held request receives one acknowledge, and `hb_rack` is never high in two consecutive cycles. Writes to unmapped addresses change no operand, result or status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_wr | input | 1 | Host write strobe, one cycle per write |
| hb_rd | input | 1 | Host read request, held until acknowledged |
| hb_addr | input | ADDR_W | Host word address |
| hb_wdata | input | DATA_W | Host write data |
| hb_rdata | output | DATA_W | Host read data, valid with hb_rack |
| hb_rack | output | 1 | Read acknowledge, one cycle |
| op_data | output | N_WORDS*DATA_W | Operand vector to the engine, word i at bits i*DATA_W |
| op_start | output | 1 | One-cycle start pulse to the engine |
| res_valid | input | 1 | Engine result word valid |
| res_last | input | 1 | Marks the final result word |
| res_data | input | DATA_W | Engine result word |

## Verification
The bench goes after four hazards. A result read issued before the engine answers must stay unacknowledged; a design that acknowledged it early would return stale data. The stalled acknowledge must come exactly one cycle after the final word and carry that word's value; an off-by-one capture would hand back the previous result. An operand write that lands in the same cycle as the engine's final word must leave the status at zero; a design that let the set win would report a stale hash as done for the new operands. Writes to non-final and unmapped addresses are also driven, to catch a stray start pulse or a corrupted operand.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  typedef enum logic [1:0] {
    ACC_WORD   = 2'd0,
    ACC_STATUS = 2'd1,
    ACC_NONE   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/hrb_addr_decode.sv
module hrb_addr_decode
  import hrb_pkg::*;
#(
  parameter int N_WORDS = 4,
  localparam int ADDR_W = $clog2(N_WORDS + 1),
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(N_WORDS);

  always_comb begin
    idx = addr[IDX_W-1:0];
    if (addr < STATUS_ADDR)       kind = ACC_WORD;
    else if (addr == STATUS_ADDR) kind = ACC_STATUS;
    else                          kind = ACC_NONE;
  end
endmodule

// File: rtl/hrb_operand_bank.sv
module hrb_operand_bank #(
  parameter int DATA_W  = 32,
  parameter int N_WORDS = 4,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [N_WORDS*DATA_W-1:0]   op_data,
  output logic                        op_start
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic [DATA_W-1:0] op_q [N_WORDS];
  logic              start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_WORDS; i++) op_q[i] <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_en && (idx == LAST_IDX);
      if (wr_en) op_q[idx] <= wdata;
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_flat
    assign op_data[g*DATA_W +: DATA_W] = op_q[g];
  end
  assign op_start = start_q;

  assert_start_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    op_start |-> $past(wr_en && idx == LAST_IDX));

  assert_operand_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> op_q[$past(idx)] == $past(wdata));
endmodule

// File: rtl/hrb_result_bank.sv
module hrb_result_bank #(
  parameter int DATA_W  = 32,
  parameter int N_WORDS = 4,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              res_valid,
  input  logic              res_last,
  input  logic [DATA_W-1:0] res_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic [DATA_W-1:0] mem [N_WORDS];
  logic [IDX_W-1:0]  wptr;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (res_valid) mem[wptr] <= res_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
    end else if (res_valid) begin
      if (res_last || wptr == LAST_IDX) wptr <= '0;
      else                              wptr <= wptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        done_q <= 1'b0;
    else if (clr)                   done_q <= 1'b0;
    else if (res_valid && res_last) done_q <= 1'b1;
  end

  assign rd_word = mem[rd_idx];
  assign done    = done_q;

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> !done);

  assert_last_sets_done_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_last && !clr) |=> done);

  assert_wrap_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_last) |=> wptr == '0);

  assert_word_stored_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> mem[$past(wptr)] == $past(res_data));
endmodule

// File: rtl/hrb_read_port.sv
module hrb_read_port
  import hrb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  acc_kind_e         kind,
  input  logic              done,
  input  logic [DATA_W-1:0] res_word,
  output logic [DATA_W-1:0] rdata,
  output logic              rack
);
  logic [DATA_W-1:0] rdata_q;
  logic              rack_q;
  logic              acked_word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q      <= '0;
      rack_q       <= 1'b0;
      acked_word_q <= 1'b0;
    end else begin
      rack_q       <= 1'b0;
      acked_word_q <= 1'b0;
      if (rd_req && !rack_q) begin
        unique case (kind)
          ACC_STATUS: begin
            rack_q  <= 1'b1;
            rdata_q <= {{(DATA_W-1){1'b0}}, done};
          end
          ACC_WORD: begin
            if (done) begin
              rack_q       <= 1'b1;
              acked_word_q <= 1'b1;
              rdata_q      <= res_word;
            end
          end
          default: begin
            rack_q  <= 1'b1;
            rdata_q <= '0;
          end
        endcase
      end
    end
  end

  assign rdata = rdata_q;
  assign rack  = rack_q;

  assert_ack_needs_request_R10: assert property (@(posedge clk) disable iff (rst)
    rack |-> $past(rd_req));

  assert_single_ack_R10: assert property (@(posedge clk) disable iff (rst)
    rack |=> !rack);

  assert_word_ack_when_done_R8: assert property (@(posedge clk) disable iff (rst)
    (rack && acked_word_q) |-> $past(done));

  assert_status_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rack && !acked_word_q) |-> rdata[DATA_W-1:1] == '0);
endmodule

// File: rtl/hash_result_regs.sv
module hash_result_regs
  import hrb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_WORDS = 4,
  localparam int ADDR_W = $clog2(N_WORDS + 1),
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hb_wr,
  input  logic                      hb_rd,
  input  logic [ADDR_W-1:0]         hb_addr,
  input  logic [DATA_W-1:0]         hb_wdata,
  output logic [DATA_W-1:0]         hb_rdata,
  output logic                      hb_rack,
  output logic [N_WORDS*DATA_W-1:0] op_data,
  output logic                      op_start,
  input  logic                      res_valid,
  input  logic                      res_last,
  input  logic [DATA_W-1:0]         res_data
);
  acc_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic              op_wr;
  logic              done;
  logic [DATA_W-1:0] res_word;

  hrb_addr_decode #(.N_WORDS(N_WORDS)) u_decode (
    .addr (hb_addr),
    .kind (kind),
    .idx  (idx)
  );

  assign op_wr = hb_wr && (kind == ACC_WORD);

  hrb_operand_bank #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_operands (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (op_wr),
    .idx      (idx),
    .wdata    (hb_wdata),
    .op_data  (op_data),
    .op_start (op_start)
  );

  hrb_result_bank #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_results (
    .clk       (clk),
    .rst       (rst),
    .clr       (op_wr),
    .res_valid (res_valid),
    .res_last  (res_last),
    .res_data  (res_data),
    .rd_idx    (idx),
    .rd_word   (res_word),
    .done      (done)
  );

  hrb_read_port #(.DATA_W(DATA_W)) u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (hb_rd),
    .kind     (kind),
    .done     (done),
    .res_word (res_word),
    .rdata    (hb_rdata),
    .rack     (hb_rack)
  );

  assert_stalled_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (hb_rd && !hb_rack && kind == ACC_WORD && !done && res_valid && res_last && !op_wr)
      |=> ##1 hb_rack);
endmodule

// File: tb/hash_result_regs_tb.sv
module hash_result_regs_tb;
  localparam int CLK_P = 10;
  localparam int DW = 32;
  localparam int NW = 4;
  localparam int AW = $clog2(NW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hb_wr = 1'b0, hb_rd = 1'b0;
  logic [AW-1:0] hb_addr = '0;
  logic [DW-1:0] hb_wdata = '0;
  logic [DW-1:0] hb_rdata;
  logic hb_rack;
  logic [NW*DW-1:0] op_data;
  logic op_start;
  logic res_valid = 1'b0, res_last = 1'b0;
  logic [DW-1:0] res_data = '0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_op [NW];
  logic [DW-1:0] exp_res [NW];

  always #(CLK_P/2) clk = ~clk;

  hash_result_regs #(.DATA_W(DW), .N_WORDS(NW)) u_dut (
    .clk(clk), .rst(rst), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_rack(hb_rack),
    .op_data(op_data), .op_start(op_start), .res_valid(res_valid),
    .res_last(res_last), .res_data(res_data)
  );

  task automatic chk(input string req, input logic [NW*DW-1:0] act, input logic [NW*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NW*DW-1:0] op_vec();
    logic [NW*DW-1:0] v;
    for (int i = 0; i < NW; i++) v[i*DW +: DW] = exp_op[i];
    return v;
  endfunction

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_wr = 1'b0;
    if (a < AW'(NW)) exp_op[a] = d;
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
    @(negedge clk);
    hb_rd = 1'b1; hb_addr = a; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!hb_rack && lat < 200);
    d = hb_rdata;
    hb_rd = 1'b0;
  endtask

  task automatic feed_results();
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      res_valid = 1'b1; res_last = (i == NW-1); res_data = exp_res[i];
    end
    @(negedge clk);
    res_valid = 1'b0; res_last = 1'b0;
  endtask

  task automatic write_all_operands(input string req);
    for (int i = 0; i < NW; i++) begin
      host_write(AW'(i), $urandom());
      chk(req, {{(NW*DW-1){1'b0}}, op_start}, (i == NW-1) ? 1 : 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int lat;
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    for (int i = 0; i < NW; i++) exp_op[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state (R3, R7, R6)
    chk("R3 reset op_start", {{(NW*DW-1){1'b0}}, op_start}, 0);
    chk("R7 reset rack", {{(NW*DW-1){1'b0}}, hb_rack}, 0);
    chk("R2 reset op_data", op_data, '0);
    host_read(AW'(NW), d, lat);
    chk("R6 status after reset", d, 0);
    chk("R7 status latency", lat, 1);

    // Operand load and start pulse (R1, R2, R3)
    write_all_operands("R3 start only on last word");
    @(negedge clk);
    chk("R3 start lasts one cycle", {{(NW*DW-1){1'b0}}, op_start}, 0);
    chk("R2 operand vector", op_data, op_vec());
    host_read(AW'(NW), d, lat);
    chk("R4 status cleared by write", d, 0);

    // Result capture and polling (R5, R6, R8)
    for (int i = 0; i < NW; i++) exp_res[i] = $urandom();
    feed_results();
    host_read(AW'(NW), d, lat);
    chk("R6 status exactly one", d, 32'h1);
    for (int i = 0; i < NW; i++) begin
      host_read(AW'(i), d, lat);
      chk("R5 result word order", d, exp_res[i]);
      chk("R8 ready read latency", lat, 1);
    end

    // Unmapped accesses (R7, R10)
    host_write(AW'(NW+1), 32'hdead_beef);
    chk("R10 unmapped write no start", {{(NW*DW-1){1'b0}}, op_start}, 0);
    chk("R10 unmapped write operands", op_data, op_vec());
    host_read(AW'(NW), d, lat);
    chk("R10 unmapped write status", d, 32'h1);
    host_read(AW'(NW+2), d, lat);
    chk("R7 unmapped read zero", d, 0);
    chk("R7 unmapped read latency", lat, 1);
    host_read(AW'(1), d, lat);
    chk("R10 unmapped write results", d, exp_res[1]);

    // Non-last write clears status; stalled read (R4, R8, R9)
    host_write(AW'(0), 32'h1234_5678);
    chk("R3 non-last write no start", {{(NW*DW-1){1'b0}}, op_start}, 0);
    for (int i = 0; i < NW; i++) exp_res[i] = $urandom();
    @(negedge clk);
    hb_rd = 1'b1; hb_addr = AW'(2);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 read stalls while not done", {{(NW*DW-1){1'b0}}, hb_rack}, 0);
    end
    for (int i = 0; i < NW; i++) begin
      res_valid = 1'b1; res_last = (i == NW-1); res_data = exp_res[i];
      @(negedge clk);
      chk("R8 no ack during capture", {{(NW*DW-1){1'b0}}, hb_rack}, 0);
    end
    res_valid = 1'b0; res_last = 1'b0;
    @(negedge clk);
    chk("R9 ack cycle after last word", {{(NW*DW-1){1'b0}}, hb_rack}, 1);
    chk("R9 stalled read new value", hb_rdata, exp_res[2]);
    hb_rd = 1'b0;
    @(negedge clk);
    chk("R10 single ack", {{(NW*DW-1){1'b0}}, hb_rack}, 0);

    // Write coinciding with final word (R4)
    for (int i = 0; i < NW-1; i++) begin
      @(negedge clk);
      res_valid = 1'b1; res_last = 1'b0; res_data = $urandom();
    end
    @(negedge clk);
    res_valid = 1'b1; res_last = 1'b1; res_data = $urandom();
    hb_wr = 1'b1; hb_addr = AW'(1); hb_wdata = 32'hcafe_0001;
    exp_op[1] = 32'hcafe_0001;
    @(negedge clk);
    res_valid = 1'b0; res_last = 1'b0; hb_wr = 1'b0;
    host_read(AW'(NW), d, lat);
    chk("R4 write beats final word", d, 0);

    // Random operations (R2, R3, R5, R6, R8)
    for (int it = 0; it < 24; it++) begin
      write_all_operands("R3 random start");
      chk("R2 random operand vector", op_data, op_vec());
      repeat ($urandom_range(0, 7)) @(negedge clk);
      if ($urandom_range(0, 1) == 1) begin
        host_read(AW'(NW), d, lat);
        chk("R6 random status before result", d, 0);
      end
      for (int i = 0; i < NW; i++) exp_res[i] = $urandom();
      feed_results();
      host_read(AW'(NW), d, lat);
      chk("R6 random status done", d, 32'h1);
      begin
        int j;
        j = $urandom_range(0, NW-1);
        host_read(AW'(j), d, lat);
        chk("R5 random result word", d, exp_res[j]);
        chk("R8 random read latency", lat, 1);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule